// File: doc/BRIEF.md
# Four-Lane Runner Game State Core

This block keeps the entire play state of an endless runner game with four lanes. Each lane is a row of obstacle cells. On every slow game tick the cells move one step toward the player, and a fresh obstacle bit for each lane enters at the far end. The player occupies one lane and moves between neighbouring lanes when an up or down pulse arrives. On each tick the block checks whether the player's lane holds an obstacle in the cell next to the player. Each such hit costs one life. When the last life is gone the game stops.

A pseudo-random source outside the block supplies the obstacle bits. A renderer outside the block reads the lane vectors, the player lane and the game-over flag to draw the screen. The score, the lives count and a three-LED lives bar go to board indicators. The tick rate comes from a clock-cycle divider parameter, so the nominal 8 ticks per second can be set for any system clock.

Top module: `lrun_core`

## Requirements
- R1: While reset is high, and on the first cycle after it, every lane is all zero, the player lane is 0, lives are 3, the score is 0, the LED bar is 3'b111 and game over is 0.
- R2: A game tick occurs once every TICK_DIV clock cycles. The first tick is sampled on the TICK_DIV-th rising edge after reset is released. Lane contents change only on tick edges.
- R3: On a tick, each lane vector shifts one cell toward bit 0. That lane's new-obstacle input enters bit LANE_LEN-1. In the lane bus, lane k occupies bits [k*LANE_LEN +: LANE_LEN].
- R4: A single-cycle pulse on up_i raises the player lane index by one at the next edge, and a pulse on down_i lowers it by one. The move waits for no tick. A move past lane 3 or below lane 0, a cycle with both pulses, and any press while game over is set all leave the lane unchanged.
- R5: A hit is taken on a tick when bit 0 of the player's lane is 1 and game over is not set. Each hit lowers lives by exactly one. The obstacle leaves bit 0 on that same tick, so it is never counted twice.
- R6: The tick on which lives reach 0 sets game over at the same edge. Game over then stays set until reset.
- R7: On the tick that sets game over, and for as long as game over is set, all four lanes read zero and the new-obstacle inputs have no effect.
- R8: The score rises by one on every 8th tick that arrives while game over is not set, counted from reset. The score does not change while game over is set.
- R9: The score is 8 bits wide and stops at 255 instead of wrapping.
- R10: LED bit i is lit exactly when lives exceed i. The bar therefore shows one LED per remaining life and is all off at game over.
- R11: A synchronous reset in the middle of a game returns the state of R1 and restarts the tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| up_i | input | 1 | Move-up pulse, one cycle |
| down_i | input | 1 | Move-down pulse, one cycle |
| new_obst_i | input | 4 | New obstacle bit per lane, sampled on ticks |
| lanes_o | output | 4*LANE_LEN | Lane vectors, lane k at [k*LANE_LEN +: LANE_LEN], bit 0 is the player zone |
| player_lane_o | output | 2 | Current player lane, 0 to 3 |
| score_o | output | 8 | Saturating score |
| lives_o | output | 2 | Lives remaining |
| life_led_o | output | 3 | Thermometer lives bar |
| game_over_o | output | 1 | Sticky end-of-game flag |

## Verification
A corrupted lane cell appears on lanes_o at the next edge. It also reaches the hit logic when it arrives at bit 0, and at that point the lives count and the LED bar diverge on the same edge. A wrong tick phase shows as lane shifts that land one or more cycles off the expected edge. A wrong per-point tick count is slower to appear: the score can run for up to eight ticks before it visibly disagrees. For that reason the score is compared on every cycle over long obstacle-free runs and again at saturation.

// File: rtl/lrun_pkg.sv
package lrun_pkg;

    localparam int LANES       = 4;
    localparam int LANE_W      = $clog2(LANES);
    localparam int START_LIVES = 3;
    localparam int LIVES_W     = $clog2(START_LIVES + 1);
    localparam int SCORE_W     = 8;

    typedef logic [LANE_W-1:0]  lane_idx_t;
    typedef logic [LIVES_W-1:0] lives_t;
    typedef logic [SCORE_W-1:0] score_t;

    typedef struct packed {
        logic   over;
        lives_t lives;
        score_t score;
    } game_stat_t;

    localparam score_t SCORE_MAX = '1;

    // next player lane for one pair of button pulses
    function automatic lane_idx_t step_lane(lane_idx_t cur, logic up, logic dn);
        if (up && !dn && cur != lane_idx_t'(LANES - 1))
            return cur + lane_idx_t'(1);
        if (dn && !up && cur != '0)
            return cur - lane_idx_t'(1);
        return cur;
    endfunction

endpackage

// File: rtl/lrun_tick_gen.sv
module lrun_tick_gen #(
    parameter int DIV = 6_250_000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/lrun_lane.sv
module lrun_lane #(
    parameter int LEN = 32
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           tick_i,
    input  logic           clr_i,
    input  logic           new_bit_i,
    output logic [LEN-1:0] cells_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)
            cells_o <= '0;
        else if (tick_i)
            cells_o <= {new_bit_i, cells_o[LEN-1:1]};
    end
endmodule

// File: rtl/lrun_player.sv
module lrun_player
    import lrun_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      freeze_i,
    input  logic      up_i,
    input  logic      down_i,
    output lane_idx_t lane_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            lane_o <= '0;
        else if (!freeze_i)
            lane_o <= step_lane(lane_o, up_i, down_i);
    end
endmodule

// File: rtl/lrun_status.sv
module lrun_status
    import lrun_pkg::*;
#(
    parameter int TICKS_PER_POINT = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   tick_i,
    input  logic                   zone_hit_i,
    output game_stat_t             stat_o,
    output logic                   fatal_o,
    output logic [START_LIVES-1:0] led_o
);
    localparam int SW = (TICKS_PER_POINT > 1) ? $clog2(TICKS_PER_POINT) : 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(TICKS_PER_POINT - 1);

    logic [SW-1:0] sub_q;
    logic          hit;
    logic          live_tick;

    assign live_tick = tick_i && !stat_o.over;
    assign hit       = live_tick && zone_hit_i;
    assign fatal_o   = hit && (stat_o.lives == lives_t'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_o.over  <= 1'b0;
            stat_o.lives <= lives_t'(START_LIVES);
            stat_o.score <= '0;
            sub_q        <= '0;
        end else begin
            if (hit)
                stat_o.lives <= stat_o.lives - lives_t'(1);
            if (fatal_o)
                stat_o.over <= 1'b1;
            if (live_tick) begin
                if (sub_q == SUB_LAST) begin
                    sub_q <= '0;
                    if (stat_o.score != SCORE_MAX)
                        stat_o.score <= stat_o.score + score_t'(1);
                end else begin
                    sub_q <= sub_q + SW'(1);
                end
            end
        end
    end

    for (genvar i = 0; i < START_LIVES; i++) begin : g_led
        assign led_o[i] = (stat_o.lives > lives_t'(i));
    end
endmodule

// File: rtl/lrun_core.sv
module lrun_core
    import lrun_pkg::*;
#(
    parameter int TICK_DIV        = 6_250_000,
    parameter int LANE_LEN        = 32,
    parameter int TICKS_PER_POINT = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      up_i,
    input  logic                      down_i,
    input  logic [LANES-1:0]          new_obst_i,
    output logic [LANES*LANE_LEN-1:0] lanes_o,
    output logic [LANE_W-1:0]         player_lane_o,
    output logic [SCORE_W-1:0]        score_o,
    output logic [LIVES_W-1:0]        lives_o,
    output logic [START_LIVES-1:0]    life_led_o,
    output logic                      game_over_o
);
    logic       game_tick;
    logic       fatal;
    logic       lane_clr;
    logic       zone_hit;
    game_stat_t stat;
    lane_idx_t  player;
    logic [LANES-1:0] zone;

    lrun_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (game_tick)
    );

    assign lane_clr = fatal || stat.over;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lrun_lane #(.LEN(LANE_LEN)) u_lane (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .tick_i    (game_tick),
            .clr_i     (lane_clr),
            .new_bit_i (new_obst_i[k]),
            .cells_o   (lanes_o[k*LANE_LEN +: LANE_LEN])
        );
        assign zone[k] = lanes_o[k*LANE_LEN];
    end

    assign zone_hit = zone[player];

    lrun_player u_player (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .freeze_i (stat.over),
        .up_i     (up_i),
        .down_i   (down_i),
        .lane_o   (player)
    );

    lrun_status #(.TICKS_PER_POINT(TICKS_PER_POINT)) u_status (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (game_tick),
        .zone_hit_i (zone_hit),
        .stat_o     (stat),
        .fatal_o    (fatal),
        .led_o      (life_led_o)
    );

    assign player_lane_o = player;
    assign score_o       = stat.score;
    assign lives_o       = stat.lives;
    assign game_over_o   = stat.over;
endmodule

// File: rtl/lrun_core_chk.sv
module lrun_core_chk
    import lrun_pkg::*;
#(
    parameter int LEN = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic [LANES*LEN-1:0]   lanes,
    input logic [LANE_W-1:0]      player,
    input logic [SCORE_W-1:0]     score,
    input logic [LIVES_W-1:0]     lives,
    input logic [START_LIVES-1:0] led,
    input logic                   over
);
    // R2: lanes move only on tick edges
    a_r2_still_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lanes));

    // R4: one lane per step at most
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (player == $past(player)) ||
                        (player == $past(player) + LANE_W'(1)) ||
                        (player == $past(player) - LANE_W'(1)));

    // R5: lives never rise and never fall by more than one
    a_r5_one_life_per_hit: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lives == $past(lives)) ||
                        (lives == $past(lives) - LIVES_W'(1)));

    // R6: game over is sticky
    a_r6_over_sticky: assert property (@(posedge clk) disable iff (rst)
        over |=> over);

    // R7: lanes empty while the game is over
    a_r7_lanes_empty: assert property (@(posedge clk) disable iff (rst)
        over |-> lanes == '0);

    // R8: score moves only after a tick and never while over
    a_r8_score_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(score)) |-> ($past(tick) && !$past(over)));

    // R9: score never goes down outside reset
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> score >= $past(score));

    // R10: bar dark at game over
    a_r10_bar_dark: assert property (@(posedge clk) disable iff (rst)
        over |-> led == '0);
endmodule

bind lrun_core lrun_core_chk #(.LEN(LANE_LEN)) u_chk (
    .clk    (clk_i),
    .rst    (rst_i),
    .tick   (game_tick),
    .lanes  (lanes_o),
    .player (player_lane_o),
    .score  (score_o),
    .lives  (lives_o),
    .led    (life_led_o),
    .over   (game_over_o)
);

// File: tb/sim_lrun_core.sv
`timescale 1ns/1ps
module sim_lrun_core;
    localparam int TDIV = 2;
    localparam int LEN  = 32;
    localparam int TPP  = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up = 1'b0;
    logic         dn = 1'b0;
    logic [3:0]   nob = 4'b0;
    logic [127:0] lanes;
    logic [1:0]   plane;
    logic [7:0]   score;
    logic [1:0]   lives;
    logic [2:0]   led;
    logic         over;

    int n_tot = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    bit [31:0] m_lane [4];
    int m_player, m_lives, m_score, m_sub, m_cnt;
    bit m_over;

    always #2.5 clk = ~clk;

    lrun_core #(.TICK_DIV(TDIV), .LANE_LEN(LEN), .TICKS_PER_POINT(TPP)) u0 (
        .clk_i         (clk),
        .rst_i         (rst),
        .up_i          (up),
        .down_i        (dn),
        .new_obst_i    (nob),
        .lanes_o       (lanes),
        .player_lane_o (plane),
        .score_o       (score),
        .lives_o       (lives),
        .life_led_o    (led),
        .game_over_o   (over)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [127:0] m_bus();
        logic [127:0] b;
        for (int k = 0; k < 4; k++) b[k*32 +: 32] = m_lane[k];
        return b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) m_lane[k] = '0;
            m_player = 0; m_lives = 3; m_score = 0; m_sub = 0; m_cnt = 0;
            m_over = 1'b0;
            cmp_on = 1'b1;
        end else begin
            bit tk, hit, fatal, was_over;
            tk = (m_cnt == TDIV - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            was_over = m_over;
            hit = tk && !was_over && m_lane[m_player][0];
            fatal = hit && (m_lives == 1);
            for (int k = 0; k < 4; k++) begin
                if (was_over || fatal) m_lane[k] = '0;
                else if (tk) begin
                    for (int c = 0; c < 31; c++) m_lane[k][c] = m_lane[k][c+1];
                    m_lane[k][31] = nob[k];
                end
            end
            if (tk && !was_over) begin
                m_sub++;
                if (m_sub == TPP) begin
                    m_sub = 0;
                    if (m_score < 255) m_score++;
                end
            end
            if (hit) m_lives--;
            if (fatal) m_over = 1'b1;
            if (!was_over) begin
                if (up && !dn && m_player < 3) m_player++;
                else if (dn && !up && m_player > 0) m_player--;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk("R2/R3/R7 lanes", lanes, m_bus());
            chk("R4 player", 128'(plane), 128'(m_player));
            chk("R5 lives", 128'(lives), 128'(m_lives));
            chk("R6 over", 128'(over), 128'(m_over));
            chk("R8 score", 128'(score), 128'(m_score));
            chk("R10 led", 128'((1 << m_lives) - 1), 128'(led));
        end
        if (cyc > 150000) begin
            n_tot++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    task automatic press(bit u, bit d);
        @(negedge clk); up = u; dn = d;
        @(negedge clk); up = 0; dn = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int guard;
        logic [7:0] frozen;
        logic [1:0] pl;
        wait_cyc(3);
        // R1 reset state
        chk("R1 lanes", lanes, '0);
        chk("R1 player", 128'(plane), 128'(0));
        chk("R1 lives", 128'(lives), 128'(3));
        chk("R1 led", 128'(led), 128'(3'b111));
        chk("R1 score", 128'(score), 128'(0));
        chk("R1 over", 128'(over), 128'(0));
        rst = 0;

        // R4 movement and limits
        repeat (5) press(1, 0);
        wait_cyc(1);
        chk("R4 ceiling", 128'(plane), 128'(3));
        press(1, 1);
        wait_cyc(1);
        chk("R4 both pressed", 128'(plane), 128'(3));
        repeat (5) press(0, 1);
        wait_cyc(1);
        chk("R4 floor", 128'(plane), 128'(0));

        // R3 obstacle in another lane passes harmlessly
        nob = 4'b0010; wait_cyc(TDIV); nob = 0;
        wait_cyc(40 * TDIV);
        chk("R5 dodge keeps lives", 128'(lives), 128'(3));

        // R5 single obstacle in player lane costs exactly one life
        nob = 4'b0001; wait_cyc(TDIV); nob = 0;
        wait_cyc(40 * TDIV);
        chk("R5 one hit", 128'(lives), 128'(2));

        // mixed random play, checked by the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) nob[k] = ($urandom_range(0, 9) == 0);
            up = ($urandom_range(0, 15) == 0);
            dn = ($urandom_range(0, 15) == 0);
        end
        up = 0; dn = 0;

        // R6 drive to game over
        nob = 4'b1111;
        guard = 0;
        while (!over && guard < 2000) begin @(negedge clk); guard++; end
        chk("R6 over reached", 128'(over), 128'(1));
        frozen = score;
        pl = plane;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            up = i[0]; dn = !i[0] && i[1];
        end
        up = 0; dn = 0;
        wait_cyc(1);
        chk("R6 over sticky", 128'(over), 128'(1));
        chk("R7 lanes empty", lanes, '0);
        chk("R8 score frozen", 128'(score), 128'(frozen));
        chk("R10 bar dark", 128'(led), 128'(0));
        chk("R4 frozen player", 128'(plane), 128'(pl));

        // R11 reset mid game
        @(negedge clk); rst = 1; nob = 0;
        wait_cyc(2);
        chk("R11 lanes", lanes, '0);
        chk("R11 lives", 128'(lives), 128'(3));
        chk("R11 score", 128'(score), 128'(0));
        chk("R11 over", 128'(over), 128'(0));
        chk("R11 player", 128'(plane), 128'(0));
        rst = 0;

        // R9 saturation with empty lanes
        wait_cyc(256 * TPP * TDIV + 20);
        chk("R9 score saturated", 128'(score), 128'(255));
        wait_cyc(50 * TDIV);
        chk("R9 score stays", 128'(score), 128'(255));

        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule